// File: doc/BRIEF.md
# Status-Flag Arithmetic and Logic Unit

This block is the arithmetic and logic stage of a small 16-bit load/store CPU. Each cycle it takes a destination operand and a source operand, a 4-bit operation code, a byte/word select and the current condition flags. It computes the result and the next values of the four condition flags. It also raises a write-back strobe that tells the register file whether the result should be stored.

Three groups of operations are supported. The binary group covers add and subtract, each with or without the incoming carry, plus packed-BCD add. The logic group covers AND, exclusive-OR, set-bits and clear-bits. The single-operand group covers shift right keeping the sign, rotate right through carry, byte exchange and sign extension. Compare and bit-test run the subtract and AND paths and update only the flags.

The next state is gathered in one combinational process and registered on the rising clock edge. Results therefore appear one cycle after the operands are presented. An asynchronous active-low reset clears the registered outputs.

Top module: `alu_flags_core`

## Requirements
- R1: Op 0 (add) gives dst+src and op 1 (add with carry) gives dst+src+C_in. C_out is the carry out of the selected width. V is set when both operands have the same sign and the result's sign differs, whether or not a carry occurs.
- R2: Op 2 (subtract) and op 4 (compare) compute dst+~src+1. Op 3 (subtract with borrow) computes dst+~src+C_in. C_out=1 means no borrow, and V follows the signed-overflow rule of R1 applied to dst and ~src.
- R3: wr_en_q is 0 after op 4 (compare), op 7 (bit test) and op 15. It is 1 after every other code.
- R4: The flag word is ordered {V,N,Z,C} from bit 3 down to bit 0. For every flag-updating operation, Z (bit 1) is set exactly when the result within the selected width is zero.
- R5: For every flag-updating operation, N (bit 2) equals bit 7 of the result in byte mode and bit 15 in word mode.
- R6: With byte_i=1, all operations except 13, 14 and 15 produce a result whose bits 15..8 are zero. Only bits 7..0 of the operands take part.
- R7: Op 5 (decimal add) adds dst, src and C_in as packed BCD digits. C_out is set when the decimal sum exceeds 99 (byte) or 9999 (word), and V is cleared.
- R8: Op 6 (AND), op 7 (bit test) and op 8 (XOR) set C to the inverse of Z and clear V.
- R9: Op 9 (set bits, dst|src) and op 10 (clear bits, dst&~src) leave all four flags equal to flags_i.
- R10: Op 11 shifts dst right one place and keeps its top bit. Op 12 shifts dst right with C_in entering the top bit. In both cases the bit shifted out becomes C and V is cleared.
- R11: Op 13 exchanges the two bytes of dst and keeps flags_i. Op 14 copies bit 7 of dst into bits 15..8 and sets flags as in R8. Both ignore byte_i.
- R12: Op 15 is reserved. It returns dst unchanged, keeps flags_i and does not request write-back.
- R13: Outputs change one clock edge after the inputs are applied. While rst_n is low, res_q, flags_q and wr_en_q are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| flags_i | input | 4 | Current flags {V,N,Z,C}; bit 0 is the carry in |
| dst_i | input | 16 | Destination operand, also the single operand |
| src_i | input | 16 | Source operand |
| res_q | output | 16 | Registered result |
| flags_q | output | 4 | Registered next flags {V,N,Z,C} |
| wr_en_q | output | 1 | Registered write-back request |

## Verification
The bound checker watches, on every cycle, the relation between the operation and the result: the write-back strobe, zeroed upper byte in byte mode, agreement of Z and N with the registered result, the C/V rule of the logic operations, held flags for set/clear/exchange/reserved, and the byte exchange and pass-through values. Arithmetic values cannot be seen from those relations alone. The carry and overflow of binary and decimal addition, the borrow sense of subtraction, and the rotate and sign-extend contents are therefore shown only by the bench's vectors, which are built around sign-boundary and decimal-wrap cases.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_DADD = 4'd5,
        OP_AND  = 4'd6,
        OP_BIT  = 4'd7,
        OP_XOR  = 4'd8,
        OP_BIS  = 4'd9,
        OP_BIC  = 4'd10,
        OP_RRA  = 4'd11,
        OP_RRC  = 4'd12,
        OP_SWPB = 4'd13,
        OP_SXT  = 4'd14,
        OP_RSVD = 4'd15
    } op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        FK_ARITH = 2'd0,
        FK_LOGIC = 2'd1,
        FK_KEEP  = 2'd2
    } flag_kind_e;

endpackage

// File: rtl/alu_bin_add.sv
module alu_bin_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ov_o
);
    logic [W:0] total;

    always_comb begin
        total = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
        sum_o = total[W-1:0];
        co_o  = total[W];
        ov_o  = (a_i[W-1] == b_i[W-1]) && (total[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_bcd_add.sv
module alu_bcd_add #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] a_i,
    input  logic [4*DIGITS-1:0] b_i,
    input  logic                ci_i,
    output logic [4*DIGITS-1:0] sum_o,
    output logic                co_o
);
    logic [DIGITS:0] carry;

    assign carry[0] = ci_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fixed;
        always_comb begin
            raw   = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, carry[g]};
            fixed = raw + 5'd6;
        end
        assign carry[g+1]      = (raw > 5'd9);
        assign sum_o[4*g +: 4] = (raw > 5'd9) ? fixed[3:0] : raw[3:0];
    end

    assign co_o = carry[DIGITS];
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_flags_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op_i,
    input  logic         byte_i,
    input  logic         ci_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] res_o,
    output logic         co_o
);
    localparam int HALF = W / 2;

    always_comb begin
        res_o = d_i;
        co_o  = d_i[0];
        case (op_i)
            OP_RRA: begin
                if (byte_i) res_o = {{HALF{1'b0}}, d_i[HALF-1], d_i[HALF-1:1]};
                else        res_o = {d_i[W-1], d_i[W-1:1]};
            end
            OP_RRC: begin
                if (byte_i) res_o = {{HALF{1'b0}}, ci_i, d_i[HALF-1:1]};
                else        res_o = {ci_i, d_i[W-1:1]};
            end
            OP_SWPB: res_o = {d_i[HALF-1:0], d_i[W-1:HALF]};
            OP_SXT:  res_o = {{HALF{d_i[HALF-1]}}, d_i[HALF-1:0]};
            default: res_o = d_i;
        endcase
    end
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic              byte_i,
    input  logic [3:0]        flags_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] res_q,
    output logic [3:0]        flags_q,
    output logic              wr_en_q
);
    localparam int HALF    = DATA_W / 2;
    localparam int W_DIGIT = DATA_W / 4;
    localparam int B_DIGIT = HALF / 4;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            fl;
        logic              we;
    } state_t;

    state_t state_d, state_q;

    op_e    op;
    flags_t fl_in;
    logic   is_sub;
    logic   add_ci;

    logic [DATA_W-1:0] b_opnd;
    logic [DATA_W-1:0] w_sum;
    logic              w_co, w_ov;
    logic [HALF-1:0]   h_sum;
    logic              h_co, h_ov;
    logic [DATA_W-1:0] wd_sum;
    logic              wd_co;
    logic [HALF-1:0]   hd_sum;
    logic              hd_co;
    logic [DATA_W-1:0] sh_res;
    logic              sh_co;

    assign op    = op_e'(op_i);
    assign fl_in = flags_t'(flags_i);

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
        b_opnd = is_sub ? ~src_i : src_i;
        case (op)
            OP_ADD:                add_ci = 1'b0;
            OP_SUB, OP_CMP:        add_ci = 1'b1;
            default:               add_ci = fl_in.c;
        endcase
    end

    alu_bin_add #(.W(DATA_W)) u_wadd (
        .a_i(dst_i), .b_i(b_opnd), .ci_i(add_ci),
        .sum_o(w_sum), .co_o(w_co), .ov_o(w_ov)
    );

    alu_bin_add #(.W(HALF)) u_hadd (
        .a_i(dst_i[HALF-1:0]), .b_i(b_opnd[HALF-1:0]), .ci_i(add_ci),
        .sum_o(h_sum), .co_o(h_co), .ov_o(h_ov)
    );

    alu_bcd_add #(.DIGITS(W_DIGIT)) u_wbcd (
        .a_i(dst_i), .b_i(src_i), .ci_i(fl_in.c),
        .sum_o(wd_sum), .co_o(wd_co)
    );

    alu_bcd_add #(.DIGITS(B_DIGIT)) u_hbcd (
        .a_i(dst_i[HALF-1:0]), .b_i(src_i[HALF-1:0]), .ci_i(fl_in.c),
        .sum_o(hd_sum), .co_o(hd_co)
    );

    alu_shift_unit #(.W(DATA_W)) u_shift (
        .op_i(op), .byte_i(byte_i), .ci_i(fl_in.c), .d_i(dst_i),
        .res_o(sh_res), .co_o(sh_co)
    );

    always_comb begin
        logic [DATA_W-1:0] raw;
        logic              c_new;
        logic              v_new;
        logic              eff_byte;
        logic              z_new;
        logic              n_new;
        flag_kind_e        kind;

        eff_byte = byte_i && (op != OP_SWPB) && (op != OP_SXT) && (op != OP_RSVD);
        raw      = dst_i;
        c_new    = 1'b0;
        v_new    = 1'b0;
        kind     = FK_KEEP;
        state_d  = '0;
        state_d.we = 1'b1;

        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                raw   = eff_byte ? {{HALF{1'b0}}, h_sum} : w_sum;
                c_new = eff_byte ? h_co : w_co;
                v_new = eff_byte ? h_ov : w_ov;
                kind  = FK_ARITH;
            end
            OP_DADD: begin
                raw   = eff_byte ? {{HALF{1'b0}}, hd_sum} : wd_sum;
                c_new = eff_byte ? hd_co : wd_co;
                kind  = FK_ARITH;
            end
            OP_AND, OP_BIT: begin
                raw  = dst_i & src_i;
                kind = FK_LOGIC;
            end
            OP_XOR: begin
                raw  = dst_i ^ src_i;
                kind = FK_LOGIC;
            end
            OP_BIS: raw = dst_i | src_i;
            OP_BIC: raw = dst_i & ~src_i;
            OP_RRA, OP_RRC: begin
                raw   = sh_res;
                c_new = sh_co;
                kind  = FK_ARITH;
            end
            OP_SWPB: raw = sh_res;
            OP_SXT: begin
                raw  = sh_res;
                kind = FK_LOGIC;
            end
            default: raw = dst_i;
        endcase

        if (eff_byte) raw[DATA_W-1:HALF] = '0;

        z_new = eff_byte ? (raw[HALF-1:0] == '0) : (raw == '0);
        n_new = eff_byte ? raw[HALF-1] : raw[DATA_W-1];

        state_d.res = raw;
        case (kind)
            FK_ARITH: state_d.fl = '{v: v_new, n: n_new, z: z_new, c: c_new};
            FK_LOGIC: state_d.fl = '{v: 1'b0, n: n_new, z: z_new, c: !z_new};
            default:  state_d.fl = fl_in;
        endcase

        if ((op == OP_CMP) || (op == OP_BIT) || (op == OP_RSVD)) state_d.we = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_q   = state_q.res;
    assign flags_q = state_q.fl;
    assign wr_en_q = state_q.we;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic              byte_i,
    input logic [3:0]        flags_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] res_q,
    input logic [3:0]        flags_q,
    input logic              wr_en_q
);
    localparam int HALF = DATA_W / 2;

    logic test_op, keep_op, nz_op, logic_op, wide_op;

    assign test_op  = (op_i == OP_CMP) || (op_i == OP_BIT) || (op_i == OP_RSVD);
    assign keep_op  = (op_i == OP_BIS) || (op_i == OP_BIC) || (op_i == OP_SWPB) || (op_i == OP_RSVD);
    assign wide_op  = (op_i == OP_SWPB) || (op_i == OP_SXT) || (op_i == OP_RSVD);
    assign logic_op = (op_i == OP_AND) || (op_i == OP_BIT) || (op_i == OP_XOR);
    assign nz_op    = !keep_op && (op_i != OP_SXT);

    AST_NO_WRITE_ON_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        test_op |=> !wr_en_q); // R3
    AST_WRITE_ON_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        !test_op |=> wr_en_q); // R3
    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_i && !wide_op) |=> (res_q[DATA_W-1:HALF] == '0)); // R6
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        nz_op |=> (flags_q[1] == ($past(byte_i) ? (res_q[HALF-1:0] == '0) : (res_q == '0)))); // R4
    AST_NEG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        nz_op |=> (flags_q[2] == ($past(byte_i) ? res_q[HALF-1] : res_q[DATA_W-1]))); // R5
    AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        logic_op |=> ((flags_q[0] == !flags_q[1]) && !flags_q[3])); // R8
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        keep_op |=> (flags_q == $past(flags_i))); // R9
    AST_BYTE_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SWPB) |=> (res_q == {$past(dst_i[HALF-1:0]), $past(dst_i[DATA_W-1:HALF])})); // R11
    AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RSVD) |=> (res_q == $past(dst_i))); // R12
endmodule

bind alu_flags_core alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i), .flags_i(flags_i),
    .dst_i(dst_i), .res_q(res_q), .flags_q(flags_q), .wr_en_q(wr_en_q)
);

// File: tb/sim_alu_flags_core.sv
module sim_alu_flags_core;
    // fields: req, op, byte, flags_in {V,N,Z,C}, dst, src, exp res, exp flags, exp we
    localparam int NV = 31;
    localparam logic [65:0] VEC [0:NV-1] = '{
        {4'd1,  4'd0,  1'b0, 4'b0000, 16'h1234, 16'h1111, 16'h2345, 4'b0000, 1'b1}, // R1
        {4'd6,  4'd0,  1'b1, 4'b0000, 16'hAB75, 16'h00C7, 16'h003C, 4'b0001, 1'b1}, // R6 byte carry
        {4'd1,  4'd0,  1'b1, 4'b0000, 16'h0040, 16'h0040, 16'h0080, 4'b1100, 1'b1}, // R1 byte V
        {4'd1,  4'd0,  1'b0, 4'b0000, 16'h7FFF, 16'h0001, 16'h8000, 4'b1100, 1'b1}, // R1 word V
        {4'd4,  4'd0,  1'b0, 4'b0000, 16'hFFFF, 16'h0001, 16'h0000, 4'b0011, 1'b1}, // R4 zero
        {4'd1,  4'd1,  1'b0, 4'b0001, 16'h0001, 16'h0001, 16'h0003, 4'b0000, 1'b1}, // R1 addc
        {4'd2,  4'd2,  1'b0, 4'b0000, 16'h0005, 16'h0003, 16'h0002, 4'b0001, 1'b1}, // R2
        {4'd5,  4'd2,  1'b0, 4'b0000, 16'h0003, 16'h0005, 16'hFFFE, 4'b0100, 1'b1}, // R5 negative
        {4'd2,  4'd2,  1'b1, 4'b0000, 16'h0080, 16'h0001, 16'h007F, 4'b1001, 1'b1}, // R2 byte V
        {4'd2,  4'd3,  1'b0, 4'b0000, 16'h0005, 16'h0003, 16'h0001, 4'b0001, 1'b1}, // R2 subc
        {4'd3,  4'd4,  1'b0, 4'b0000, 16'h0005, 16'h0005, 16'h0000, 4'b0011, 1'b0}, // R3 cmp
        {4'd7,  4'd5,  1'b1, 4'b0000, 16'h0045, 16'h0038, 16'h0083, 4'b0100, 1'b1}, // R7
        {4'd7,  4'd5,  1'b1, 4'b0000, 16'h0099, 16'h0001, 16'h0000, 4'b0011, 1'b1}, // R7 wrap 99
        {4'd7,  4'd5,  1'b0, 4'b0001, 16'h1234, 16'h5678, 16'h6913, 4'b0000, 1'b1}, // R7 word
        {4'd7,  4'd5,  1'b0, 4'b0000, 16'h9999, 16'h0001, 16'h0000, 4'b0011, 1'b1}, // R7 wrap 9999
        {4'd8,  4'd6,  1'b0, 4'b1000, 16'hF0F0, 16'h0FF0, 16'h00F0, 4'b0001, 1'b1}, // R8
        {4'd8,  4'd6,  1'b0, 4'b0000, 16'hF0F0, 16'h0F0F, 16'h0000, 4'b0010, 1'b1}, // R8 zero
        {4'd3,  4'd7,  1'b1, 4'b0000, 16'h0080, 16'h0080, 16'h0080, 4'b0101, 1'b0}, // R3 bit test
        {4'd8,  4'd8,  1'b0, 4'b0000, 16'h8000, 16'h0001, 16'h8001, 4'b0101, 1'b1}, // R8 xor
        {4'd9,  4'd9,  1'b0, 4'b1010, 16'h00F0, 16'h0F00, 16'h0FF0, 4'b1010, 1'b1}, // R9 set bits
        {4'd9,  4'd10, 1'b0, 4'b0101, 16'h0FF0, 16'h00F0, 16'h0F00, 4'b0101, 1'b1}, // R9 clear bits
        {4'd6,  4'd9,  1'b1, 4'b0000, 16'h12F0, 16'h0001, 16'h00F1, 4'b0000, 1'b1}, // R6 set bits
        {4'd10, 4'd11, 1'b0, 4'b0000, 16'h8003, 16'h0000, 16'hC001, 4'b0101, 1'b1}, // R10 rra
        {4'd10, 4'd11, 1'b1, 4'b0000, 16'hFF81, 16'h0000, 16'h00C0, 4'b0101, 1'b1}, // R10 rra byte
        {4'd10, 4'd12, 1'b0, 4'b0001, 16'h0002, 16'h0000, 16'h8001, 4'b0100, 1'b1}, // R10 rrc
        {4'd10, 4'd12, 1'b1, 4'b0000, 16'h0001, 16'h0000, 16'h0000, 4'b0011, 1'b1}, // R10 rrc byte
        {4'd11, 4'd13, 1'b1, 4'b1111, 16'h12AB, 16'h0000, 16'hAB12, 4'b1111, 1'b1}, // R11 swap
        {4'd11, 4'd14, 1'b1, 4'b0000, 16'h0080, 16'h0000, 16'hFF80, 4'b0101, 1'b1}, // R11 sext
        {4'd11, 4'd14, 1'b0, 4'b0000, 16'hFF7F, 16'h0000, 16'h007F, 4'b0001, 1'b1}, // R11 sext pos
        {4'd12, 4'd15, 1'b0, 4'b0110, 16'h1357, 16'hFFFF, 16'h1357, 4'b0110, 1'b0}, // R12
        {4'd2,  4'd2,  1'b0, 4'b0000, 16'h8000, 16'h0001, 16'h7FFF, 4'b1001, 1'b1}  // R2 word V
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic [15:0] dst_i = '0;
    logic [15:0] src_i = '0;
    logic [15:0] res_q;
    logic [3:0]  flags_q;
    logic        wr_en_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_flags_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i), .flags_i(flags_i),
        .dst_i(dst_i), .src_i(src_i), .res_q(res_q), .flags_q(flags_q), .wr_en_q(wr_en_q)
    );

    task automatic check_out(input int req, input logic [15:0] er, input logic [3:0] ef, input logic ew);
        checks++;
        if (res_q !== er || flags_q !== ef || wr_en_q !== ew) begin
            fails++;
            $display("FAIL R%0d: res=%h flags=%b we=%b expected res=%h flags=%b we=%b",
                     req, res_q, flags_q, wr_en_q, er, ef, ew);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out(13, 16'h0000, 4'b0000, 1'b0); // R13 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            op_i    = VEC[i][61:58];
            byte_i  = VEC[i][57];
            flags_i = VEC[i][56:53];
            dst_i   = VEC[i][52:37];
            src_i   = VEC[i][36:21];
            @(negedge clk);
            check_out(int'(VEC[i][65:62]), VEC[i][20:5], VEC[i][4:1], VEC[i][0]);
        end
        // R13 latency: new inputs do not show before the next edge
        op_i = 4'd0; byte_i = 1'b0; flags_i = 4'b0000; dst_i = 16'h0001; src_i = 16'h0001;
        #1;
        check_out(13, 16'h7FFF, 4'b1001, 1'b1);
        @(negedge clk);
        check_out(13, 16'h0002, 4'b0000, 1'b1);
        // R13 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check_out(13, 16'h0000, 4'b0000, 1'b0);
        rst_n = 1'b1;
        // R3 back-to-back: compare then add restores write-back
        op_i = 4'd4; dst_i = 16'h0009; src_i = 16'h0002;
        @(negedge clk);
        check_out(3, 16'h0007, 4'b0001, 1'b0);
        op_i = 4'd0;
        @(negedge clk);
        check_out(3, 16'h000B, 4'b0000, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R13: watchdog expired, actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule